// File: doc/BRIEF.md
# Fractional Stream Rate Limiter

This block sits inline on a valid/ready stream and holds the share of clock cycles that carry accepted beats at or below a fraction that can be changed at run time. The fraction is given as an unsigned numerator and denominator. When the numerator is at least the denominator, the block does not throttle. The block holds no data. Data, last and user pass straight through. To throttle, the block gates the handshake: in a stall cycle it lowers the ready it gives upstream and the valid it gives downstream in the same cycle.

A signed credit accumulator gains the numerator every clock and loses the denominator for every beat that is transferred. A new beat may start only while the credit is zero or positive. Positive credit is capped at numerator minus one, so an idle stream cannot build up a burst allowance. There are two pacing modes, selected by a single input. Word mode may stall before any beat. Frame mode never stalls inside a frame: the debt a frame builds up is paid back as idle cycles after its last beat, before the next frame may begin.

Top module: `rate_throttle`

## Requirements
- R1: After reset the credit is zero and no frame is open, so a beat offered in the first cycle after reset passes at once.
- R2: When rate_num >= rate_den the block never stalls: every offered beat passes in the cycle it is offered.
- R3: In word mode (pace_mode = 0) at a ratio of 1/3 with a continuous source and sink, exactly one beat passes every three cycles, and two beats are never accepted in consecutive cycles (10 beats in 30 cycles from reset).
- R4: In word mode at a ratio of 2/3 from reset, with continuous flow, 20 beats pass in 30 cycles.
- R5: Credit gained while no beat is transferred is capped at rate_num − 1. At a ratio of 1/3, after any idle stretch the first two beats are three cycles apart.
- R6: In frame mode (pace_mode = 1), once the first beat of a frame has been accepted, every later beat of that frame that is offered is passed without a stall.
- R7: In frame mode the debt of a frame is repaid after its last beat (s_last = 1). At a ratio of 1/2 with back-to-back 4-beat frames, each frame is followed by exactly 4 idle cycles, so 16 beats pass in 32 cycles.
- R8: In a stall cycle s_ready and m_valid are both low. Data, last and user reach the output unchanged and in order.
- R9: A beat offered while m_ready is low is not transferred, s_ready stays low, and no credit is spent, so it passes in the first cycle m_ready is high.
- R10: Word mode ignores frame boundaries. At a ratio of 1/2 with 4-beat frames, the block stalls between beats of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_num | input | RATE_W | Ratio numerator, credit gained per cycle |
| rate_den | input | RATE_W | Ratio denominator, credit spent per beat |
| pace_mode | input | 1 | 0 = word pacing, 1 = frame pacing |
| s_data | input | DATA_W | Upstream data |
| s_last | input | 1 | Upstream end of frame |
| s_user | input | USER_W | Upstream sideband |
| s_valid | input | 1 | Upstream beat offered |
| s_ready | output | 1 | Upstream beat accepted |
| m_data | output | DATA_W | Downstream data |
| m_last | output | 1 | Downstream end of frame |
| m_user | output | USER_W | Downstream sideband |
| m_valid | output | 1 | Downstream beat offered |
| m_ready | input | 1 | Downstream ready |

## Verification
Two things can happen in the same cycle: the credit update and the close of a frame. When a frame's last beat is accepted, that beat both pushes the credit further negative and ends the frame. The stall must begin in the very next cycle and must not start one beat early inside the frame. The bench drives back-to-back 4-beat frames at a ratio of 1/2. It judges the result from the exact bitmap of accepted beats: four beats in a row, then exactly four idle cycles, then a new frame. A second case lines up back-pressure with available credit and checks that a refused beat spends no credit.

// File: rtl/rt_pkg.sv
package rt_pkg;
   typedef enum logic {
      PACE_WORD  = 1'b0,
      PACE_FRAME = 1'b1
   } pace_mode_e;

   // width of the signed credit register for a given ratio width and slack
   function automatic int credit_width(input int rate_w, input int slack_w);
      return rate_w + slack_w + 1;
   endfunction
endpackage

// File: rtl/rt_credit.sv
module rt_credit #(
   parameter int RATE_W  = 8,
   parameter int SLACK_W = 8,
   parameter int ACC_W   = rt_pkg::credit_width(RATE_W, SLACK_W)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [RATE_W-1:0]       rate_num,
   input  logic [RATE_W-1:0]       rate_den,
   input  logic                    xfer,
   output logic                    throttle,
   output logic                    credit_ok,
   output logic signed [ACC_W-1:0] acc
);
   localparam int SUM_W = ACC_W + 1;
   localparam logic signed [SUM_W-1:0] FLOOR = -(SUM_W'(1) <<< (ACC_W - 1));

   logic signed [SUM_W-1:0] num_s, den_s, cap_s, sum_s, acc_s;
   logic signed [ACC_W-1:0] acc_nx;

   assign throttle  = (rate_num < rate_den);
   assign credit_ok = !acc[ACC_W-1];

   always_comb begin
      num_s  = $signed({{(SUM_W-RATE_W){1'b0}}, rate_num});
      den_s  = $signed({{(SUM_W-RATE_W){1'b0}}, rate_den});
      cap_s  = num_s - SUM_W'(1);
      acc_s  = {acc[ACC_W-1], acc};
      sum_s  = acc_s + num_s - (xfer ? den_s : '0);
      if (!throttle)
         acc_nx = '0;
      else if (sum_s > cap_s)
         acc_nx = cap_s[ACC_W-1:0];
      else if (sum_s < FLOOR)
         acc_nx = FLOOR[ACC_W-1:0];
      else
         acc_nx = sum_s[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc_nx;
   end
endmodule

// File: rtl/rt_frame_track.sv
module rt_frame_track (
   input  logic clk,
   input  logic rst,
   input  logic xfer,
   input  logic last,
   output logic in_frame
);
   always_ff @(posedge clk) begin
      if (rst)       in_frame <= 1'b0;
      else if (xfer) in_frame <= !last;
   end
endmodule

// File: rtl/rt_gate.sv
module rt_gate #(
   parameter int DATA_W = 8,
   parameter int USER_W = 1
) (
   input  logic              allow,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic [USER_W-1:0] s_user,
   input  logic              s_valid,
   output logic              s_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_last,
   output logic [USER_W-1:0] m_user,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              xfer
);
   assign s_ready = m_ready & allow;
   assign m_valid = s_valid & allow;
   assign m_data  = s_data;
   assign m_last  = s_last;
   assign m_user  = s_user;
   assign xfer    = s_valid & m_ready & allow;
endmodule

// File: rtl/rate_throttle.sv
module rate_throttle #(
   parameter int DATA_W  = 8,
   parameter int USER_W  = 1,
   parameter int RATE_W  = 8,
   parameter int SLACK_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] rate_num,
   input  logic [RATE_W-1:0] rate_den,
   input  logic              pace_mode,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic [USER_W-1:0] s_user,
   input  logic              s_valid,
   output logic              s_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_last,
   output logic [USER_W-1:0] m_user,
   output logic              m_valid,
   input  logic              m_ready
);
   import rt_pkg::*;

   localparam int ACC_W = credit_width(RATE_W, SLACK_W);

   generate
      if (DATA_W < 1)  begin : g_bad_data  $error("DATA_W must be at least 1");  end
      if (USER_W < 1)  begin : g_bad_user  $error("USER_W must be at least 1");  end
      if (RATE_W < 2)  begin : g_bad_rate  $error("RATE_W must be at least 2");  end
      if (SLACK_W < 1) begin : g_bad_slack $error("SLACK_W must be at least 1"); end
   endgenerate

   logic                    xfer, throttle, credit_ok, in_frame, allow;
   logic signed [ACC_W-1:0] acc;
   pace_mode_e              mode;

   assign mode  = pace_mode_e'(pace_mode);
   assign allow = !throttle || credit_ok || (mode == PACE_FRAME && in_frame);

   rt_credit #(.RATE_W(RATE_W), .SLACK_W(SLACK_W), .ACC_W(ACC_W)) u_credit (
      .clk(clk), .rst(rst), .rate_num(rate_num), .rate_den(rate_den),
      .xfer(xfer), .throttle(throttle), .credit_ok(credit_ok), .acc(acc)
   );

   rt_frame_track u_frame (
      .clk(clk), .rst(rst), .xfer(xfer), .last(s_last), .in_frame(in_frame)
   );

   rt_gate #(.DATA_W(DATA_W), .USER_W(USER_W)) u_gate (
      .allow(allow), .s_data(s_data), .s_last(s_last), .s_user(s_user),
      .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data), .m_last(m_last),
      .m_user(m_user), .m_valid(m_valid), .m_ready(m_ready), .xfer(xfer)
   );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
   parameter int RATE_W = 8,
   parameter int ACC_W  = 17
) (
   input logic                    clk,
   input logic                    rst,
   input logic [RATE_W-1:0]       rate_num,
   input logic [RATE_W-1:0]       rate_den,
   input logic                    pace_mode,
   input logic                    s_valid,
   input logic                    s_ready,
   input logic                    m_valid,
   input logic                    m_ready,
   input logic                    in_frame,
   input logic signed [ACC_W-1:0] acc
);
   logic signed [ACC_W-1:0] cap;
   assign cap = $signed({{(ACC_W-RATE_W){1'b0}}, rate_num}) - ACC_W'(1);

   p_hs_pair_r8: assert property (@(posedge clk) disable iff (rst)
      (s_valid && s_ready) == (m_valid && m_ready));

   p_stall_both_r8: assert property (@(posedge clk) disable iff (rst)
      (s_valid && !m_valid) |-> !s_ready);

   p_open_r2: assert property (@(posedge clk) disable iff (rst)
      (rate_num >= rate_den && s_valid) |-> m_valid);

   p_frame_nostall_r6: assert property (@(posedge clk) disable iff (rst)
      (pace_mode && in_frame && s_valid) |-> m_valid);

   p_cap_r5: assert property (@(posedge clk) disable iff (rst)
      (rate_num != '0 && rate_num < rate_den && $stable(rate_num) && $stable(rate_den))
      |-> (acc <= cap));
endmodule

bind rate_throttle rt_checker #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst(rst), .rate_num(rate_num), .rate_den(rate_den),
   .pace_mode(pace_mode), .s_valid(s_valid), .s_ready(s_ready),
   .m_valid(m_valid), .m_ready(m_ready), .in_frame(in_frame), .acc(acc)
);

// File: tb/test_rate_throttle.sv
`timescale 1ns/1ps
module test_rate_throttle;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] rate_num = 8'd1, rate_den = 8'd1;
   logic       pace_mode = 1'b0;
   logic [7:0] s_data = '0;
   logic       s_last = 1'b0;
   logic [0:0] s_user = '0;
   logic       s_valid = 1'b0;
   logic       s_ready;
   logic [7:0] m_data;
   logic       m_last;
   logic [0:0] m_user;
   logic       m_valid;
   logic       m_ready = 1'b0;

   int total = 0, bad = 0;
   bit hist [64];
   int nbeats;
   bit path_ok, gate_ok;

   always #5 clk = ~clk;

   rate_throttle i_rate_throttle (
      .clk(clk), .rst(rst), .rate_num(rate_num), .rate_den(rate_den),
      .pace_mode(pace_mode), .s_data(s_data), .s_last(s_last), .s_user(s_user),
      .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data), .m_last(m_last),
      .m_user(m_user), .m_valid(m_valid), .m_ready(m_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int num, input int den, input bit fm);
      @(negedge clk);
      s_valid = 1'b0; m_ready = 1'b0; rst = 1'b1;
      rate_num = 8'(num); rate_den = 8'(den); pace_mode = fm;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // offer beats every cycle for ncyc cycles; record accepted-beat bitmap
   task automatic pump(input int ncyc, input int flen, input bit rdy);
      int bif = 0;
      int dcnt = 0;
      nbeats = 0; path_ok = 1'b1; gate_ok = 1'b1;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         s_valid = 1'b1; m_ready = rdy;
         s_last  = (bif == flen - 1);
         s_user  = s_last;
         s_data  = 8'(dcnt);
         #1;
         hist[c] = m_valid && m_ready;
         if (m_data != s_data || m_last != s_last || m_user != s_user) path_ok = 1'b0;
         if (rdy && (m_valid != s_ready)) gate_ok = 1'b0;
         if (m_valid && m_ready) begin
            nbeats++;
            bif  = s_last ? 0 : bif + 1;
            dcnt = dcnt + 1;
         end
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      s_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      do_reset(1, 4, 1'b0);
      s_valid = 1'b1; m_ready = 1'b1;
      #1;
      chk(m_valid == 1'b1, "R1 m_valid after reset", m_valid, 1);
      chk(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
   endtask

   task automatic t_open;
      do_reset(5, 5, 1'b0);
      pump(20, 1000, 1'b1);
      chk(nbeats == 20, "R2 beats at 5/5", nbeats, 20);
      do_reset(7, 3, 1'b1);
      pump(10, 3, 1'b1);
      chk(nbeats == 10, "R2 beats at 7/3", nbeats, 10);
   endtask

   task automatic t_third;
      bit adj = 1'b0;
      do_reset(1, 3, 1'b0);
      pump(30, 1000, 1'b1);
      chk(nbeats == 10, "R3 beats at 1/3", nbeats, 10);
      for (int c = 1; c < 30; c++) if (hist[c] && hist[c-1]) adj = 1'b1;
      chk(!adj, "R3 back-to-back beats", adj, 0);
      chk(gate_ok, "R8 stall drops both ready and valid", gate_ok, 1);
      chk(path_ok, "R8 data path unchanged", path_ok, 1);
   endtask

   task automatic t_two_thirds;
      do_reset(2, 3, 1'b0);
      pump(30, 1000, 1'b1);
      chk(nbeats == 20, "R4 beats at 2/3", nbeats, 20);
   endtask

   task automatic t_idle_cap;
      do_reset(1, 3, 1'b0);
      idle(20);
      pump(6, 1000, 1'b1);
      chk(nbeats == 2, "R5 beats after idle", nbeats, 2);
      chk(hist[0] && !hist[1] && !hist[2] && hist[3], "R5 spacing after idle",
          {hist[0], hist[1], hist[2], hist[3]}, 4'b1001);
   endtask

   task automatic t_frame;
      bit run_ok = 1'b1;
      do_reset(1, 2, 1'b1);
      pump(32, 4, 1'b1);
      chk(nbeats == 16, "R7 beats in frame mode", nbeats, 16);
      for (int f = 0; f < 4; f++)
         for (int k = 0; k < 4; k++) if (!hist[f*8 + k]) run_ok = 1'b0;
      chk(run_ok, "R6 no stall inside frame", run_ok, 1);
      chk(!hist[4] && !hist[5] && !hist[6] && !hist[7] && hist[8],
          "R7 idle cycles after last", {hist[4], hist[5], hist[6], hist[7], hist[8]}, 5'b00001);
      chk(path_ok, "R8 last and user unchanged", path_ok, 1);
   endtask

   task automatic t_word_frames;
      do_reset(1, 2, 1'b0);
      pump(8, 4, 1'b1);
      chk(nbeats == 4, "R10 beats at 1/2 word mode", nbeats, 4);
      chk(hist[0] && !hist[1] && hist[2], "R10 stall inside frame",
          {hist[0], hist[1], hist[2]}, 3'b101);
   endtask

   task automatic t_backpressure;
      do_reset(1, 3, 1'b0);
      pump(5, 1000, 1'b0);
      chk(nbeats == 0, "R9 no beat while m_ready low", nbeats, 0);
      chk(s_ready == 1'b0, "R9 s_ready low under back-pressure", s_ready, 0);
      chk(m_valid == 1'b1, "R9 m_valid offered under back-pressure", m_valid, 1);
      pump(3, 1000, 1'b1);
      chk(hist[0], "R9 credit kept, beat passes at once", hist[0], 1);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      t_reset();
      t_open();
      t_third();
      t_two_thirds();
      t_idle_cap();
      t_frame();
      t_word_frames();
      t_backpressure();
      finish_run();
   end
endmodule